// File: doc/BRIEF.md
# Shifting Push-Down Stack

This block is a last-in, first-out store whose storage cells physically move. The store is a chain of eight 8-bit cells, with cell 0 as the top. A push writes the new word into cell 0 and moves every held word one cell deeper. A pop moves every held word one cell toward the top, so the next word appears at cell 0. The top cell drives a fixed output port. Because of this, a consumer reads the current top word without asserting an address or a read strobe.

A separate 4-bit up/down occupancy counter follows the number of held words and produces the empty and full flags. A push and a pop are requested on the same enable input, and a select input chooses between them. A request that would overflow or underflow the store is dropped. Such a request leaves both the cells and the counter unchanged.

Top module: `shift_stack`

## Requirements
- R1: While rst_ni is low, and after it is released, the stack is empty: empty_o=1, full_o=0, top_o=0.
- R2: On a clock edge with en_i=1, push_i=1 and full_o=0, the word on data_i becomes top_o, and the word that was on top moves one cell deeper.
- R3: On a clock edge with en_i=1, push_i=0 and empty_o=0, the top word is discarded and the word one cell deeper becomes top_o.
- R4: The number of held words goes up by one for each accepted push and down by one for each accepted pop. empty_o is 1 exactly when the count is 0, and full_o is 1 exactly when the count is 8. The two flags are never 1 together.
- R5: When en_i=0, top_o, empty_o and full_o do not change, whatever push_i and data_i hold.
- R6: A push while full_o=1 is dropped: full_o stays 1, top_o is unchanged, and eight later pops return the original eight words in reverse order of pushing.
- R7: A pop while empty_o=1 is dropped: empty_o stays 1, and the counter does not wrap. A single push that follows clears empty_o.
- R8: Cells vacated at the bottom by a pop are loaded with zero, so top_o reads 0 whenever the stack is empty.
- R9: Pushing 45, 12 and 23, then popping, gives top 23 before the pop. A later push of 10 leaves 10, 12 and 45 from the top downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operation enable |
| push_i | input | 1 | 1 selects push, 0 selects pop |
| data_i | input | 8 | Word to push |
| top_o | output | 8 | Word held in the top cell |
| empty_o | output | 1 | No words held |
| full_o | output | 1 | Eight words held |

## Verification
The bench first runs the worked sequence of three pushes, one pop and one push. This sequence separates a correct deepening shift from one that overwrites cell 0 or shifts in the wrong direction. A complete fill followed by a complete drain with distinct words exposes any cell that is skipped or duplicated. The same run shows the full and empty flags switching at 8 and at 0.

A push made while full and a pop made while empty show whether a dropped request still shifts data or moves the counter. A stretch with enable low and busy data shows whether the select input leaks through. Alternating pushes and pops at a middle depth show that the two directions do not interfere.

// File: rtl/shift_stack_pkg.sv
package shift_stack_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stack_op_e;
endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import shift_stack_pkg::*;
(
  input  logic      en_i,
  input  logic      push_i,
  input  logic      empty_i,
  input  logic      full_i,
  output stack_op_e op_o
);
  // Overflowing push and underflowing pop collapse to hold.
  always_comb begin
    op_o = OP_HOLD;
    if (en_i) begin
      if (push_i && !full_i)       op_o = OP_PUSH;
      else if (!push_i && !empty_i) op_o = OP_POP;
    end
  end
endmodule

// File: rtl/stack_shifter.sv
module stack_shifter
  import shift_stack_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stack_op_e        op_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] top_o
);
  logic [WIDTH-1:0] cell_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_cell
    logic [WIDTH-1:0] from_above;
    logic [WIDTH-1:0] from_below;

    if (k == 0) begin : g_top
      assign from_above = data_i;
    end else begin : g_mid_a
      assign from_above = cell_q[k-1];
    end

    if (k == DEPTH - 1) begin : g_bot
      assign from_below = '0;
    end else begin : g_mid_b
      assign from_below = cell_q[k+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cell_q[k] <= '0;
      end else begin
        case (op_i)
          OP_PUSH: cell_q[k] <= from_above;
          OP_POP:  cell_q[k] <= from_below;
          default: cell_q[k] <= cell_q[k];
        endcase
      end
    end
  end

  assign top_o = cell_q[0];
endmodule

// File: rtl/occupancy_ctr.sv
module occupancy_ctr
  import shift_stack_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  stack_op_e op_i,
  output logic      empty_o,
  output logic      full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case (op_i)
        OP_PUSH: cnt_q <= cnt_q + CNT_W'(1);
        OP_POP:  cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/shift_stack.sv
module shift_stack
  import shift_stack_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] top_o,
  output logic             empty_o,
  output logic             full_o
);
  stack_op_e op;

  stack_ctrl i_ctrl (
    .en_i    (en_i),
    .push_i  (push_i),
    .empty_i (empty_o),
    .full_i  (full_o),
    .op_o    (op)
  );

  stack_shifter #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .data_i (data_i),
    .top_o  (top_o)
  );

  occupancy_ctr #(.DEPTH(DEPTH)) i_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .empty_o (empty_o),
    .full_o  (full_o)
  );
endmodule

// File: rtl/shift_stack_chk.sv
module shift_stack_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             push_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] top_o,
  input logic             empty_o,
  input logic             full_o
);
  assert_flags_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));

  assert_push_lands_on_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && push_i && !full_o) |=> (top_o == $past(data_i)) && !empty_o);

  assert_pop_clears_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !push_i && full_o) |=> !full_o);

  assert_idle_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(top_o) && $stable(empty_o) && $stable(full_o));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && push_i && full_o) |=> full_o && $stable(top_o));

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !push_i && empty_o) |=> empty_o && !full_o);

  assert_empty_top_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (top_o == '0));
endmodule

bind shift_stack shift_stack_chk #(.WIDTH(WIDTH)) i_shift_stack_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .push_i  (push_i),
  .data_i  (data_i),
  .top_o   (top_o),
  .empty_o (empty_o),
  .full_o  (full_o)
);

// File: tb/test_shift_stack.sv
module test_shift_stack;
  localparam int DEPTH = 8;

  typedef struct {
    logic [7:0] top;
    logic       empty;
    logic       full;
    string      tag;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       push_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] top_o;
  logic       empty_o;
  logic       full_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] model[$];
  exp_t       exp_q[$];

  always #5 clk_i = ~clk_i;

  shift_stack i_shift_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .push_i  (push_i),
    .data_i  (data_i),
    .top_o   (top_o),
    .empty_o (empty_o),
    .full_o  (full_o)
  );

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one operation at the falling edge and predicts the result.
  task automatic drive(bit en, bit push, logic [7:0] d, string tag);
    exp_t e;
    @(negedge clk_i);
    en_i   = en;
    push_i = push;
    data_i = d;
    if (en && push && model.size() < DEPTH) model.push_front(d);
    else if (en && !push && model.size() > 0) void'(model.pop_front());
    e.top   = (model.size() > 0) ? model[0] : 8'd0;
    e.empty = (model.size() == 0);
    e.full  = (model.size() == DEPTH);
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares just after each rising edge.
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "top", top_o, e.top);
        cmp(e.tag, "empty", empty_o, e.empty);
        cmp(e.tag, "full", full_o, e.full);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, held and released
    #23;
    cmp("R1", "top", top_o, 0);
    cmp("R1", "empty", empty_o, 1);
    cmp("R1", "full", full_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp("R1", "empty_after", empty_o, 1);
    cmp("R1", "full_after", full_o, 0);

    // R9: worked example
    drive(1, 1, 8'd45, "R9");
    drive(1, 1, 8'd12, "R9");
    drive(1, 1, 8'd23, "R9");
    drive(1, 0, 8'd99, "R9");
    drive(1, 1, 8'd10, "R9");
    drive(1, 0, 8'd0, "R9");
    drive(1, 0, 8'd0, "R9");
    drive(1, 0, 8'd0, "R8");

    // R5: enable low with busy inputs
    drive(1, 1, 8'd77, "R2");
    for (int i = 0; i < 6; i++) drive(0, i[0], 8'(8'hA0 + i), "R5");
    drive(1, 0, 8'd0, "R3");

    // R2/R4: fill to eight with distinct words
    for (int i = 0; i < DEPTH; i++) drive(1, 1, 8'(8'h11 * (i + 1)), "R4");
    // R6: pushes while full
    drive(1, 1, 8'hEE, "R6");
    drive(1, 1, 8'hDD, "R6");
    drive(0, 1, 8'hCC, "R5");
    // R3/R6: drain in reverse order
    for (int i = 0; i < DEPTH; i++) drive(1, 0, 8'h00, "R3");

    // R7: pops while empty, then one push
    drive(1, 0, 8'h5A, "R7");
    drive(1, 0, 8'h5B, "R7");
    drive(1, 1, 8'h3C, "R7");
    drive(1, 0, 8'h00, "R7");
    drive(1, 0, 8'h00, "R7");

    // R8: partial fill then drain, top reads zero when empty
    for (int i = 0; i < 3; i++) drive(1, 1, 8'(8'hF0 + i), "R2");
    for (int i = 0; i < 3; i++) drive(1, 0, 8'h00, "R8");

    // R2/R3: alternating at mid depth
    for (int i = 0; i < 4; i++) drive(1, 1, 8'(8'h40 + i), "R2");
    for (int i = 0; i < 6; i++) begin
      drive(1, 1, 8'(8'h80 + i), "R2");
      drive(1, 0, 8'h00, "R3");
    end
    for (int i = 0; i < 5; i++) drive(1, 0, 8'h00, "R3");

    drive(0, 0, 8'h00, "R5");
    @(posedge clk_i);
    @(posedge clk_i);
    #3;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule